// File: doc/BRIEF.md
# Dual-Mode Radio Configuration Port

This block is the control front end of a transceiver. After a power-on reset, two pins, a data pin and a clock pin, act as a direct two-bit operating-mode select. The block decodes them continuously into an operating-mode code. The first time a third pin, the select pin, is seen high, the block switches for good into a three-wire serial port. From then on the same two pins carry a serial clock and a bidirectional data line, and the mode output holds its last decoded value. Only another power-on reset brings the block back to pin-select operation.

In serial operation, a frame lasts while select is high. The first byte of a frame is a command: a read or write flag and a starting register index. Every following complete byte is written to, or read from, one of three 8-bit configuration registers. The register index advances after each byte and wraps. During a read, the block drives the data pin MSB-first and asserts an output enable. All pins are sampled on a faster system clock. Rising edges of the serial clock are detected against that clock.

Top module: `radio_cfg_if`

## Requirements
- R1: After power-on reset, every configuration register is zero, `serial_o` is 0, `mode_o` is 0 (sleep) and `sdo_oe_o` is 0.
- R2: While in pin-select operation, `mode_o` gives the decode of {`sdata_i`,`sclk_i`} one system clock after the pins settle: 11 gives 1 (receive), 00 gives 0 (sleep), 01 gives 2 (transmit on-off keyed) and 10 gives 3 (transmit amplitude keyed).
- R3: The first cycle that `sel_i` is high sets `serial_o` to 1, and it stays 1 until the next power-on reset. `mode_o` keeps the value it had before that cycle and ignores later pin activity.
- R4: While `sel_i` is high, each rising edge of `sclk_i` shifts in one bit from `sdata_i`, MSB first. The first complete byte of a frame is a command: bit 7 = 1 means read and 0 means write, and bits 1:0 give the starting index. Index 3 is treated as 0.
- R5: In a write frame, each complete byte after the command is stored in the current register, and the index then advances 0→1→2→0.
- R6: If `sel_i` falls before 8 bits of a byte have arrived, that partial byte changes no register.
- R7: Rising edges of `sclk_i` while `sel_i` is low change no register and do not count toward the next frame.
- R8: In a read frame, after the command byte `sdo_oe_o` is 1 and `sdo_o` presents the current register MSB first. The next bit appears after each rising edge of `sclk_i`, and the block moves on to the next register after 8 bits, with the same wrap as R5.
- R9: `sdo_oe_o` is 0 from the cycle after `sel_i` is seen low.
- R10: `cfg_o` holds register k in bits [8k+7:8k], and `dcr_en_o` equals bit 0 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| sel_i | input | 1 | Select pin: mode switch and frame enable |
| sclk_i | input | 1 | Mode bit 0 / serial clock |
| sdata_i | input | 1 | Mode bit 1 / serial data in |
| mode_o | output | 2 | Decoded operating mode |
| serial_o | output | 1 | High once serial operation is entered |
| cfg_o | output | 24 | The three configuration registers |
| dcr_en_o | output | 1 | Data-recovery enable (register 0 bit 0) |
| sdo_o | output | 1 | Serial data out during reads |
| sdo_oe_o | output | 1 | Output enable for the data pin |

## Verification
A bit counter that is off by one shows up at the ports within the first write frame. The stored byte is rotated, or the command is read as data, so `cfg_o` is wrong right after the frame ends. A stale index pointer appears as a wrong register in a later write or a wrong bit on `sdo_o` in a read. A read that crosses the wrap point shows it within 8 serial clocks. A latch that failed to stick, or a counter that was not cleared on a dropped select, only shows after a later pin-select change or a later frame. For that reason, random frames of random length and start index are mixed with truncated frames and with clock edges outside frames.

// File: rtl/radio_cfg_pkg.sv
package radio_cfg_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_RX     = 2'd1,
        MODE_TX_OOK = 2'd2,
        MODE_TX_ASK = 2'd3
    } op_mode_e;

    // Direct pin decode used before serial operation is entered
    function automatic op_mode_e decode_pins(input logic pin_d, input logic pin_c);
        case ({pin_d, pin_c})
            2'b11:   return MODE_RX;
            2'b00:   return MODE_SLEEP;
            2'b01:   return MODE_TX_OOK;
            default: return MODE_TX_ASK;
        endcase
    endfunction

endpackage

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch
    import radio_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_i,
    input  logic     pin_d_i,
    input  logic     pin_c_i,
    output logic     serial_o,
    output op_mode_e mode_o
);

    logic     serial_q;
    op_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            serial_q <= 1'b0;
            mode_q   <= MODE_SLEEP;
        end else begin
            if (sel_i)
                serial_q <= 1'b1;
            if (!serial_q && !sel_i)
                mode_q <= decode_pins(pin_d_i, pin_c_i);
        end
    end

    assign serial_o = serial_q;
    assign mode_o   = mode_q;

    a_r3_serial_sticky: assert property (@(posedge clk) disable iff (rst)
        serial_q |=> serial_q);

    a_r3_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (serial_q || sel_i) |=> $stable(mode_q));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [REG_W-1:0]          wr_data_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output logic [REG_W-1:0]          rd_data_o,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    logic [REG_W-1:0] regs_q [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[k] <= '0;
            else if (wr_en_i && (int'(wr_idx_i) == k))
                regs_q[k] <= wr_data_i;
        end
        assign regs_o[k*REG_W +: REG_W] = regs_q[k];
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (int'(rd_idx_i) == k)
                rd_data_o = regs_q[k];
    end

    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/cfg_serial_engine.sv
module cfg_serial_engine #(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 3,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             sclk_i,
    input  logic             sdata_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [REG_W-1:0] wr_data_o,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic [REG_W-1:0] rd_data_i,
    output logic             sdo_o,
    output logic             sdo_oe_o
);

    logic             sclk_q;
    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] shift_q, shift_nxt, tx_q;
    logic [IDX_W-1:0] ptr_q, ptr_inc, cmd_idx;
    logic             in_data_q, is_read_q, oe_q;
    logic             rise, byte_done;

    assign rise      = sel_i && sclk_i && !sclk_q;
    assign byte_done = rise && (int'(cnt_q) == REG_W - 1);
    assign shift_nxt = {shift_q[REG_W-2:0], sdata_i};
    assign cmd_idx   = (int'(shift_nxt[IDX_W-1:0]) >= NUM_REGS) ? '0 : shift_nxt[IDX_W-1:0];
    assign ptr_inc   = (int'(ptr_q) == NUM_REGS - 1) ? '0 : ptr_q + 1'b1;
    assign rd_idx_o  = in_data_q ? ptr_inc : cmd_idx;

    always_ff @(posedge clk) begin
        if (rst)
            sclk_q <= 1'b0;
        else
            sclk_q <= sclk_i;
    end

    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            cnt_q     <= '0;
            shift_q   <= '0;
            tx_q      <= '0;
            in_data_q <= 1'b0;
            is_read_q <= 1'b0;
            oe_q      <= 1'b0;
            if (rst)
                ptr_q <= '0;
        end else if (rise) begin
            shift_q <= shift_nxt;
            cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
            if (byte_done && !in_data_q) begin
                in_data_q <= 1'b1;
                is_read_q <= shift_nxt[REG_W-1];
                ptr_q     <= cmd_idx;
                if (shift_nxt[REG_W-1]) begin
                    oe_q <= 1'b1;
                    tx_q <= rd_data_i;
                end
            end else if (byte_done) begin
                ptr_q <= ptr_inc;
                if (is_read_q)
                    tx_q <= rd_data_i;
            end else if (in_data_q && is_read_q) begin
                tx_q <= {tx_q[REG_W-2:0], 1'b0};
            end
        end
    end

    assign wr_en_o   = byte_done && in_data_q && !is_read_q;
    assign wr_idx_o  = ptr_q;
    assign wr_data_o = shift_nxt;
    assign sdo_o     = tx_q[REG_W-1];
    assign sdo_oe_o  = oe_q;

    a_r9_oe_release: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> !oe_q);

    a_r6_count_cleared: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> (cnt_q == '0 && !in_data_q));

    a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) < NUM_REGS);

    a_r8_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> !wr_en_o);

endmodule

// File: rtl/radio_cfg_if.sv
module radio_cfg_if
    import radio_cfg_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int NUM_REGS = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      por_i,
    input  logic                      sel_i,
    input  logic                      sclk_i,
    input  logic                      sdata_i,
    output logic [1:0]                mode_o,
    output logic                      serial_o,
    output logic [NUM_REGS*REG_W-1:0] cfg_o,
    output logic                      dcr_en_o,
    output logic                      sdo_o,
    output logic                      sdo_oe_o
);

    op_mode_e         mode;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [REG_W-1:0] wr_data, rd_data;

    cfg_mode_latch u_latch (
        .clk      (clk),
        .rst      (por_i),
        .sel_i    (sel_i),
        .pin_d_i  (sdata_i),
        .pin_c_i  (sclk_i),
        .serial_o (serial_o),
        .mode_o   (mode)
    );

    cfg_serial_engine #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_engine (
        .clk       (clk),
        .rst       (por_i),
        .sel_i     (sel_i),
        .sclk_i    (sclk_i),
        .sdata_i   (sdata_i),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .rd_idx_o  (rd_idx),
        .rd_data_i (rd_data),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o)
    );

    cfg_regfile #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst       (por_i),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .regs_o    (cfg_o)
    );

    assign mode_o   = mode;
    assign dcr_en_o = cfg_o[0];

    a_r3_no_oe_before_serial: assert property (@(posedge clk) disable iff (por_i)
        sdo_oe_o |-> serial_o);

    a_r5_write_needs_serial: assert property (@(posedge clk) disable iff (por_i)
        wr_en |-> serial_o);

endmodule

// File: tb/test_radio_cfg_if.sv
module test_radio_cfg_if;

    logic        clk = 1'b0;
    logic        por_i = 1'b1;
    logic        sel_i = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic [1:0]  mode_o;
    logic        serial_o;
    logic [23:0] cfg_o;
    logic        dcr_en_o, sdo_o, sdo_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] m_reg [3];
    int m_ptr;

    always #2.5 clk = ~clk;

    radio_cfg_if i_radio_cfg_if (
        .clk(clk), .por_i(por_i), .sel_i(sel_i), .sclk_i(sclk_i), .sdata_i(sdata_i),
        .mode_o(mode_o), .serial_o(serial_o), .cfg_o(cfg_o), .dcr_en_o(dcr_en_o),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
    );

    function automatic logic [1:0] exp_mode(input logic d, input logic c);
        case ({d, c})
            2'b11: return 2'd1;
            2'b00: return 2'd0;
            2'b01: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic int next_idx(input int p);
        return (p == 2) ? 0 : p + 1;
    endfunction

    function automatic logic [23:0] model_flat();
        return {m_reg[2], m_reg[1], m_reg[0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic d);
        sdata_i = d; sclk_i = 1'b1; tick(2);
        sclk_i = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) pulse(b[i]);
    endtask

    task automatic check_regs(input string req);
        chk(cfg_o == model_flat(), req, cfg_o, model_flat());
        chk(dcr_en_o == m_reg[0][0], "R10 dcr_en", dcr_en_o, m_reg[0][0]);
    endtask

    task automatic do_write(input logic [1:0] idx, input int n);
        sel_i = 1'b1; tick(2);
        send_byte({1'b0, 5'b0, idx[1:0]} | {1'b0, 5'($urandom), 2'b0});
        m_ptr = (idx == 2'd3) ? 0 : int'(idx);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = 8'($urandom);
            send_byte(v);
            m_reg[m_ptr] = v;
            m_ptr = next_idx(m_ptr);
        end
        sel_i = 1'b0; tick(2);
        check_regs("R5 write");
    endtask

    task automatic do_read(input logic [1:0] idx, input int n);
        sel_i = 1'b1; tick(2);
        send_byte({1'b1, 5'($urandom), idx});
        m_ptr = (idx == 2'd3) ? 0 : int'(idx);
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                chk(sdo_oe_o == 1'b1, "R8 oe during read", sdo_oe_o, 1);
                chk(sdo_o == m_reg[m_ptr][i], "R8 read bit", sdo_o, m_reg[m_ptr][i]);
                pulse(1'($urandom));
            end
            m_ptr = next_idx(m_ptr);
        end
        sel_i = 1'b0; tick(1);
        chk(sdo_oe_o == 1'b0, "R9 oe released", sdo_oe_o, 0);
        tick(1);
        check_regs("R8 read leaves regs");
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        for (int k = 0; k < 3; k++) m_reg[k] = 8'h00;
        tick(4);
        por_i = 1'b0;
        tick(1);
        // R1 reset state
        chk(cfg_o == 24'h0, "R1 regs zero", cfg_o, 0);
        chk(serial_o == 1'b0, "R1 parallel", serial_o, 0);
        chk(mode_o == 2'd0, "R1 sleep", mode_o, 0);
        chk(sdo_oe_o == 1'b0, "R1 oe low", sdo_oe_o, 0);

        // R2 pin decode, all four codes and random sequences
        for (int t = 0; t < 12; t++) begin
            logic d, c;
            d = (t < 4) ? t[1] : 1'($urandom);
            c = (t < 4) ? t[0] : 1'($urandom);
            sdata_i = d; sclk_i = c; tick(2);
            chk(mode_o == exp_mode(d, c), "R2 decode", mode_o, exp_mode(d, c));
            chk(cfg_o == 24'h0, "R7 pins do not write", cfg_o, 0);
        end

        // R3 switch to serial while pins select amplitude-keyed transmit
        sdata_i = 1'b1; sclk_i = 1'b0; tick(2);
        sel_i = 1'b1; tick(1);
        chk(serial_o == 1'b1, "R3 enter serial", serial_o, 1);
        chk(mode_o == 2'd3, "R3 mode held", mode_o, 3);
        sel_i = 1'b0; tick(2);
        sdata_i = 1'b0; sclk_i = 1'b0; tick(2);
        chk(mode_o == 2'd3, "R3 mode ignores pins", mode_o, 3);
        chk(serial_o == 1'b1, "R3 sticky", serial_o, 1);

        // R4 R5 directed: start at index 2 and wrap, index 3 as 0
        do_write(2'd2, 3);
        do_write(2'd3, 1);
        do_read(2'd1, 3);

        // R6 partial byte after command and after a full byte
        sel_i = 1'b1; tick(2);
        send_byte(8'h00);
        for (int i = 0; i < 5; i++) pulse(1'($urandom));
        sel_i = 1'b0; tick(2);
        check_regs("R6 partial dropped");
        sel_i = 1'b1; tick(2);
        send_byte(8'h01);
        m_ptr = 1;
        send_byte(8'hA5); m_reg[1] = 8'hA5;
        for (int i = 0; i < 7; i++) pulse(1'b1);
        sel_i = 1'b0; tick(2);
        check_regs("R6 partial after full byte");

        // R7 edges outside a frame are ignored and do not misalign the next frame
        for (int i = 0; i < 5; i++) pulse(1'($urandom));
        check_regs("R7 idle edges");
        do_write(2'd0, 1);
        chk(mode_o == 2'd3, "R3 mode after frames", mode_o, 3);

        // random mix
        for (int t = 0; t < 40; t++) begin
            if ($urandom_range(0, 1) == 0)
                do_write(2'($urandom), $urandom_range(0, 4));
            else
                do_read(2'($urandom), $urandom_range(1, 4));
        end
        // R10 dcr enable both ways
        do_write(2'd0, 0);
        sel_i = 1'b1; tick(2); send_byte(8'h00); send_byte(8'h01); m_reg[0] = 8'h01;
        sel_i = 1'b0; tick(2);
        check_regs("R10 dcr set");

        // R1 again: a new power-on reset returns to pin-select operation
        por_i = 1'b1; tick(3); por_i = 1'b0;
        for (int k = 0; k < 3; k++) m_reg[k] = 8'h00;
        tick(1);
        chk(serial_o == 1'b0, "R1 serial cleared", serial_o, 0);
        chk(cfg_o == 24'h0, "R1 regs cleared", cfg_o, 0);
        sdata_i = 1'b1; sclk_i = 1'b1; tick(2);
        chk(mode_o == 2'd1, "R2 decode after reset", mode_o, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule